// File: doc/BRIEF.md
# Timestamp-Ordered Hit Stream Merger

This block takes one local hit stream and a configurable number of child-link hit streams and combines them into one output stream in timestamp order. Every input stream must already be in non-decreasing time order. Each source has its own FIFO: 16 entries for the local source and 256 for each child link. On entry, a per-source correction value is added to the timestamp so that all sources refer to one common time base. The block is meant for a chain or tree of readout chips, where each chip merges its own hits with the streams of the chips below it.

Merging waits until every source FIFO holds at least one word. It then offers the head with the smallest corrected timestamp on a valid/ready output. A source with no real hits sends timeout markers. A marker carries the source's current time and promises that nothing older will follow on that input, so a quiet source does not hold up the merge forever. A configuration bit decides what happens to a marker once it has been selected: it is either forwarded like a hit or discarded. Upstream links are never back-pressured. A word that arrives at a full FIFO is dropped and counted.

Hit word layout (48 bits): bit 47 is the marker flag, bits 46:40 the chip/channel ID, bits 39:31 the energy, bits 30:0 the timestamp.

Top module: `hitmerge_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` is 0 and every overflow counter reads 0.
- R2: `out_valid` stays 0 in any cycle where at least one source FIFO is empty.
- R3: When every FIFO holds a word, the selected head is the one with the smallest timestamp (bits 30:0). On a tie, the lowest source index wins: the local source is index 0 and child k is index k+1.
- R4: The selected FIFO is popped only on a cycle with `out_valid` and `out_ready` both 1. While `out_ready` is 0, `out_data` holds its value.
- R5: On entry, the source's offset is added modulo 2^31 to bits 30:0 of the word. Bits 47:31 pass through unchanged.
- R6: Markers (bit 47 = 1) take part in selection like hits. With `drop_markers` = 0, a selected marker is output like a hit.
- R7: With `drop_markers` = 1, a selected marker is removed in the cycle it is selected, whatever the state of `out_ready`, and `out_valid` stays 0 in that cycle.
- R8: A word that arrives while its FIFO is full is discarded. The source's overflow counter then increments, saturating at 2^CNT_W-1. The input side has no ready signal.
- R9: The local FIFO counts as full at 16 words and each child FIFO at 256 words. Fullness is evaluated before any pop in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| drop_markers | input | 1 | 1: discard selected timeout markers |
| src_valid | input | NUM_CHILD+1 | Per-source word strobe (bit 0 local) |
| src_data | input | 48*(NUM_CHILD+1) | Per-source words, source s at bits 48*s+47:48*s |
| src_offset | input | 31*(NUM_CHILD+1) | Per-source timestamp correction |
| out_valid | output | 1 | Merged word available |
| out_ready | input | 1 | Consumer accepts word |
| out_data | output | 48 | Merged word |
| ovf_count | output | CNT_W*(NUM_CHILD+1) | Per-source saturating drop counters |

## Verification
A wrong FIFO pointer or count shows up at the ports in the next cycle with a valid output. There the merged word differs from the oldest queued word, or `out_valid` rises while some source is still empty. A bad selector breaks the timestamp order within one pop, and on ties the wrong source wins. A fault on the full side shows up as an overflow count that differs from the expected count the cycle after the first dropped word.

// File: rtl/hm_pkg.sv
package hm_pkg;
   localparam int WORD_W = 48;
   localparam int TS_W   = 31;
   localparam int ID_W   = 7;
   localparam int EN_W   = 9;

   typedef logic [TS_W-1:0] hm_ts_t;

   typedef struct packed {
      logic             marker;
      logic [ID_W-1:0]  chan;
      logic [EN_W-1:0]  energy;
      hm_ts_t           ts;
   } hm_word_t;
endpackage

// File: rtl/hm_fifo.sv
module hm_fifo #(
   parameter int DEPTH = 16,
   parameter int W     = 48
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         full,
   output logic         empty
);
   localparam int AW = $clog2(DEPTH);

   logic [W-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [AW:0]   count;
   logic          do_push, do_pop;

   assign full    = (count == (AW+1)'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         count <= count + (AW+1)'(do_push) - (AW+1)'(do_pop);
      end
   end
endmodule

// File: rtl/hm_source.sv
module hm_source
   import hm_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  hm_word_t         in_word,
   input  hm_ts_t           offset,
   input  logic             pop,
   output hm_word_t         head,
   output logic             nonempty,
   output logic [CNT_W-1:0] ovf
);
   hm_word_t corr;
   logic     full, empty;
   logic [WORD_W-1:0] head_raw;

   always_comb begin
      corr    = in_word;
      corr.ts = in_word.ts + offset;
   end

   hm_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (in_valid),
      .wdata (corr),
      .pop   (pop),
      .head  (head_raw),
      .full  (full),
      .empty (empty)
   );

   assign head     = hm_word_t'(head_raw);
   assign nonempty = !empty;

   always_ff @(posedge clk) begin
      if (!rst_n)
         ovf <= '0;
      else if (in_valid && full && (ovf != '1))
         ovf <= ovf + 1'b1;
   end
endmodule

// File: rtl/hm_select.sv
module hm_select
   import hm_pkg::*;
#(
   parameter int NSRC = 3,
   localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  hm_ts_t        ts [NSRC],
   output logic [SW-1:0] sel
);
   hm_ts_t best;
   always_comb begin
      sel  = '0;
      best = ts[0];
      for (int i = 1; i < NSRC; i++) begin
         if (ts[i] < best) begin
            best = ts[i];
            sel  = SW'(i);
         end
      end
   end
endmodule

// File: rtl/hitmerge_top.sv
module hitmerge_top
   import hm_pkg::*;
#(
   parameter int NUM_CHILD   = 2,
   parameter int LOCAL_DEPTH = 16,
   parameter int CHILD_DEPTH = 256,
   parameter int CNT_W       = 8
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             drop_markers,
   input  logic [NUM_CHILD:0]               src_valid,
   input  logic [WORD_W*(NUM_CHILD+1)-1:0]  src_data,
   input  logic [TS_W*(NUM_CHILD+1)-1:0]    src_offset,
   output logic                             out_valid,
   input  logic                             out_ready,
   output logic [WORD_W-1:0]                out_data,
   output logic [CNT_W*(NUM_CHILD+1)-1:0]   ovf_count
);
   localparam int NSRC = NUM_CHILD + 1;
   localparam int SW   = (NSRC > 1) ? $clog2(NSRC) : 1;

   if (NUM_CHILD < 1) begin : g_bad_child
      $error("hitmerge_top: NUM_CHILD must be at least 1");
   end
   if (LOCAL_DEPTH < 2 || (LOCAL_DEPTH & (LOCAL_DEPTH-1)) != 0) begin : g_bad_ldepth
      $error("hitmerge_top: LOCAL_DEPTH must be a power of two >= 2");
   end
   if (CHILD_DEPTH < 2 || (CHILD_DEPTH & (CHILD_DEPTH-1)) != 0) begin : g_bad_cdepth
      $error("hitmerge_top: CHILD_DEPTH must be a power of two >= 2");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("hitmerge_top: CNT_W must be at least 1");
   end

   hm_word_t          heads [NSRC];
   hm_ts_t            head_ts [NSRC];
   logic [NSRC-1:0]   nonempty_vec;
   logic [NSRC-1:0]   pop_vec;
   logic [TS_W*NSRC-1:0] head_ts_flat;
   logic [SW-1:0]     sel;
   hm_word_t          sel_word;
   logic              all_ne, drop_now, consume;

   for (genvar s = 0; s < NSRC; s++) begin : g_src
      localparam int DEPTH_S = (s == 0) ? LOCAL_DEPTH : CHILD_DEPTH;
      hm_source #(.DEPTH(DEPTH_S), .CNT_W(CNT_W)) u_src (
         .clk      (clk),
         .rst_n    (rst_n),
         .in_valid (src_valid[s]),
         .in_word  (hm_word_t'(src_data[WORD_W*s +: WORD_W])),
         .offset   (src_offset[TS_W*s +: TS_W]),
         .pop      (pop_vec[s]),
         .head     (heads[s]),
         .nonempty (nonempty_vec[s]),
         .ovf      (ovf_count[CNT_W*s +: CNT_W])
      );
      assign head_ts[s] = heads[s].ts;
      assign head_ts_flat[TS_W*s +: TS_W] = heads[s].ts;
      assign pop_vec[s] = consume && (sel == SW'(s));
   end

   hm_select #(.NSRC(NSRC)) u_sel (
      .ts  (head_ts),
      .sel (sel)
   );

   assign all_ne    = &nonempty_vec;
   assign sel_word  = heads[sel];
   assign drop_now  = all_ne && drop_markers && sel_word.marker;
   assign out_valid = all_ne && !drop_now;
   assign out_data  = sel_word;
   assign consume   = drop_now || (out_valid && out_ready);
endmodule

// File: rtl/hm_checker.sv
module hm_checker #(
   parameter int NSRC  = 3,
   parameter int CNT_W = 8,
   parameter int TS_W  = 31
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    drop_markers,
   input logic                    out_valid,
   input logic                    out_ready,
   input logic [47:0]             out_data,
   input logic [NSRC-1:0]         nonempty_vec,
   input logic [TS_W*NSRC-1:0]    head_ts_flat,
   input logic [CNT_W*NSRC-1:0]   ovf_count
);
   // R1
   a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |=> !out_valid && ovf_count == '0);

   // R2
   a_r2_wait_all: assert property (@(posedge clk) disable iff (!rst_n)
      !(&nonempty_vec) |-> !out_valid);

   // R4
   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=>
         (drop_markers != $past(drop_markers)) || (out_valid && $stable(out_data)));

   // R7
   a_r7_no_marker_out: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && drop_markers |-> !out_data[47]);

   for (genvar s = 0; s < NSRC; s++) begin : g_chk
      // R3
      a_r3_oldest: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> out_data[TS_W-1:0] <= head_ts_flat[TS_W*s +: TS_W]);
      // R8
      a_r8_ovf_mono: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> ovf_count[CNT_W*s +: CNT_W] >= $past(ovf_count[CNT_W*s +: CNT_W]));
   end
endmodule

bind hitmerge_top hm_checker #(.NSRC(NUM_CHILD+1), .CNT_W(CNT_W), .TS_W(hm_pkg::TS_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .drop_markers (drop_markers),
   .out_valid    (out_valid),
   .out_ready    (out_ready),
   .out_data     (out_data),
   .nonempty_vec (nonempty_vec),
   .head_ts_flat (head_ts_flat),
   .ovf_count    (ovf_count)
);

// File: tb/hitmerge_top_bench.sv
module hitmerge_top_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NCH   = 2;
   localparam int NSRC  = NCH + 1;
   localparam int CNT_W = 8;
   localparam int LDEP  = 16;
   localparam int CDEP  = 256;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic drop_markers = 1'b0;
   logic [NSRC-1:0] src_valid = '0;
   logic [48*NSRC-1:0] src_data = '0;
   logic [31*NSRC-1:0] src_offset = '0;
   logic out_valid;
   logic out_ready = 1'b0;
   logic [47:0] out_data;
   logic [CNT_W*NSRC-1:0] ovf_count;

   always #(CLK_PERIOD/2) clk = ~clk;

   hitmerge_top #(.NUM_CHILD(NCH), .LOCAL_DEPTH(LDEP), .CHILD_DEPTH(CDEP), .CNT_W(CNT_W)) u_hitmerge_top (
      .clk(clk), .rst_n(rst_n), .drop_markers(drop_markers), .src_valid(src_valid),
      .src_data(src_data), .src_offset(src_offset), .out_valid(out_valid),
      .out_ready(out_ready), .out_data(out_data), .ovf_count(ovf_count));

   int checks = 0;
   int errors = 0;
   bit finished = 0;
   string cur_req = "R1";

   // reference model
   logic [47:0] q [NSRC][$];
   int          m_ovf [NSRC];
   logic [30:0] offs [NSRC];
   int          tsn [NSRC];
   // stimulus for next step
   bit          st_v [NSRC];
   logic [47:0] st_w [NSRC];
   bit          st_rdy;

   function automatic int depth_of(int s);
      return (s == 0) ? LDEP : CDEP;
   endfunction

   task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic model_clear();
      for (int s = 0; s < NSRC; s++) begin
         q[s].delete();
         m_ovf[s] = 0;
         st_v[s] = 0;
      end
   endtask

   // one clock: compare, apply stimulus, advance model
   task automatic step();
      bit allne, dropnow, ev;
      int sel;
      bit fullb [NSRC];
      @(negedge clk);
      allne = 1;
      for (int s = 0; s < NSRC; s++) if (q[s].size() == 0) allne = 0;
      sel = 0;
      if (allne)
         for (int s = 1; s < NSRC; s++)
            if (q[s][0][30:0] < q[sel][0][30:0]) sel = s;
      dropnow = allne && drop_markers && q[sel][0][47];
      ev = allne && !dropnow;
      check(cur_req, "out_valid", 64'(out_valid), 64'(ev));
      if (ev) check(cur_req, "out_data", 64'(out_data), 64'(q[sel][0]));
      for (int s = 0; s < NSRC; s++)
         check("R8", "ovf_count", 64'(ovf_count[CNT_W*s +: CNT_W]), 64'(m_ovf[s]));
      // drive
      out_ready = st_rdy;
      for (int s = 0; s < NSRC; s++) begin
         src_valid[s] = st_v[s];
         src_data[48*s +: 48] = st_w[s];
         src_offset[31*s +: 31] = offs[s];
         fullb[s] = q[s].size() >= depth_of(s);
      end
      if (allne && (dropnow || (ev && st_rdy))) void'(q[sel].pop_front());
      for (int s = 0; s < NSRC; s++) begin
         if (st_v[s]) begin
            if (fullb[s]) begin
               if (m_ovf[s] < (1 << CNT_W) - 1) m_ovf[s]++;
            end else begin
               q[s].push_back({st_w[s][47:31], st_w[s][30:0] + offs[s]});
            end
         end
         st_v[s] = 0;
      end
   endtask

   task automatic mk(int s, bit marker, int dts);
      tsn[s] += dts;
      st_v[s] = 1;
      st_w[s] = {marker, 7'(s + 16), 9'($urandom), 31'(tsn[s])};
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0;
      src_valid = '0;
      model_clear();
      repeat (2) @(negedge clk);
      cur_req = "R1";
      checks++;
      if (out_valid !== 1'b0) begin errors++; $display("FAIL R1 out_valid actual=%0b expected=0", out_valid); end
      check("R1", "ovf during reset", 64'(ovf_count), 64'(0));
      rst_n = 1;
   endtask

   // watchdog
   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int s = 0; s < NSRC; s++) begin offs[s] = 31'(s * 3); tsn[s] = 0; end
      st_rdy = 1;
      model_clear();
      do_reset();
      step();

      // R2: only local hits, children empty -> nothing leaves
      cur_req = "R2";
      for (int i = 0; i < 5; i++) begin mk(0, 0, 2); step(); end
      repeat (6) step();

      // R6: children send markers, forwarded since drop_markers=0
      cur_req = "R6";
      mk(1, 1, 20); mk(2, 1, 20); step();
      repeat (8) step();

      // R3 ties: equal corrected timestamps on all sources
      cur_req = "R3";
      offs[0] = 0; offs[1] = 0; offs[2] = 0;
      for (int s = 0; s < NSRC; s++) tsn[s] = 100;
      for (int s = 0; s < NSRC; s++) mk(s, 0, 0);
      step();
      repeat (6) step();

      // R4/R5: random traffic, random ready, non-zero offsets
      cur_req = "R4 R5";
      offs[0] = 31'd7; offs[1] = 31'd0; offs[2] = 31'd13;
      for (int c = 0; c < 4000; c++) begin
         for (int s = 0; s < NSRC; s++)
            if ($urandom % 100 < 35) mk(s, ($urandom % 6) == 0, $urandom % 3);
         st_rdy = ($urandom % 4) != 0;
         step();
      end

      // R7: markers discarded regardless of ready
      cur_req = "R7";
      drop_markers = 1;
      for (int c = 0; c < 4000; c++) begin
         for (int s = 0; s < NSRC; s++)
            if ($urandom % 100 < 35) mk(s, ($urandom % 3) == 0, $urandom % 3);
         st_rdy = ($urandom % 3) != 0;
         step();
      end
      drop_markers = 0;

      // R9 / R8: depths and saturation
      do_reset();
      cur_req = "R9";
      st_rdy = 0;
      step();
      for (int i = 0; i < 20; i++) begin mk(0, 0, 1); step(); end
      step();
      check("R9", "local ovf after 20 words", 64'(ovf_count[0 +: CNT_W]), 64'(4));
      for (int i = 0; i < 258; i++) begin mk(1, 0, 1); step(); end
      step();
      check("R9", "child0 ovf after 258 words", 64'(ovf_count[CNT_W +: CNT_W]), 64'(2));
      cur_req = "R8";
      for (int i = 0; i < 280; i++) begin mk(0, 0, 1); step(); end
      step();
      check("R8", "local ovf saturated", 64'(ovf_count[0 +: CNT_W]), 64'(255));
      check("R8", "child1 ovf untouched", 64'(ovf_count[2*CNT_W +: CNT_W]), 64'(0));

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule